// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the time base for a pulse-width modulation generator. A divide counter, set by two prescale fields, turns the system clock into time-base ticks. On each tick a 16-bit counter advances in one of four modes: up, down, up-then-down, or frozen. The active period limits the count. Software can write the period straight into the active register, or into a shadow copy that moves across when the counter arrives at zero. A run field lets the counter run freely, halt at once, or finish its current cycle and then rest at zero.

Downstream compare and output logic use the counter value and the direction flag. They also use two single-cycle event pulses, one for arrival at zero and one for arrival at the period. All settings come from one 16-bit control word. Any change to that word restarts the divide counter, so a new divisor takes effect from a clean boundary.

Top module: `pwm_timebase`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the counter, both event outputs, the direction flag, the divide counter and both period registers to 0. After reset, with a divisor of 1 and free run, every tick leaves the count at 0 and raises both `zero_evt` and `prd_evt`.
- R2: The control word fields are: bits [1:0] count mode, bit [2] period-load select, bits [5:3] coarse prescale, bits [8:6] fine prescale, bits [10:9] run control, and bits [15:11] unused. In count mode 0 (up), each advancing tick adds one. A tick taken at a count at or above the period gives 0. `dir_down` is 0 in this mode.
- R3: In count mode 1 (down), each advancing tick subtracts one, and a tick taken at 0 reloads the active period. `dir_down` is 1 in this mode.
- R4: In count mode 2 (up-down), the counter rises to the period and then falls to 0, and repeats. `dir_down` becomes 1 on the tick that reaches the period and returns to 0 on the tick that reaches 0.
- R5: In count mode 3 (freeze), the counter holds its value and no event is raised.
- R6: `zero_evt` and `prd_evt` are registered with the count. Each is high for one clock after an advancing tick leaves the counter at 0 or at the active period, respectively.
- R7: Run control 00 stops the counter from the next tick. The count holds, and no event is raised.
- R8: Run control 01 lets the counter go on until it arrives at 0, then hold there. Run control 11 (and 10) runs freely.
- R9: The time-base divisor is the coarse divisor 2^coarse times the fine divisor. The fine divisor is 1 for field value 0 and 2·n for a nonzero value n. This gives a range from 1 to 1792 system clocks per tick.
- R10: Any change in the control word, including the unused bits, restarts the divide counter. The first tick after a change comes one full divisor after the clock that sees the change.
- R11: While `tb_en` is low, the divide counter and the counter both hold.
- R12: With the period-load bit at 1, a period write updates the active period at that clock edge.
- R13: With the period-load bit at 0, a period write goes only to the shadow register. The shadow value moves into the active period on the tick that brings the counter to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl | input | 16 | Control word: mode, period-load select, prescale fields, run control |
| prd_wr | input | 1 | Period write strobe |
| prd_wdata | input | 16 | Period write data |
| tb_en | input | 1 | Time-base clock enable |
| count | output | 16 | Current counter value |
| zero_evt | output | 1 | One-clock pulse when the counter arrives at zero |
| prd_evt | output | 1 | One-clock pulse when the counter arrives at the period |
| dir_down | output | 1 | Counter direction, 1 while counting down |

## Verification
The counter is run in each mode against a small fixed period, and the full count sequence is checked step by step. The up, down and up-down runs are told apart by the order of values, by where the two event pulses fall, and by the direction flag at the turning points. The prescaler is run with a mixed divisor of 12, a pure power of two, and the largest divisor of 1792. A control change in the middle of a divide interval shows that the divide counter restarts rather than carrying its phase over. Period writes are made with the time base paused, in both load modes. The old period stays visible until the next wrap in shadow mode and takes effect at once in immediate mode, which separates the two paths.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    localparam int CTRL_W   = 16;
    localparam int COARSE_W = 3;
    localparam int FINE_W   = 3;
    localparam int SPARE_W  = CTRL_W - 2 - 1 - COARSE_W - FINE_W - 2;

    typedef enum logic [1:0] {
        CNT_UP     = 2'd0,
        CNT_DOWN   = 2'd1,
        CNT_UPDOWN = 2'd2,
        CNT_FREEZE = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RUN_HALT   = 2'd0,
        RUN_FINISH = 2'd1,
        RUN_ALT    = 2'd2,
        RUN_FREE   = 2'd3
    } run_mode_e;

    // Field order, MSB first: spare, run, fine, coarse, load select, mode
    typedef struct packed {
        logic [SPARE_W-1:0]  spare;
        run_mode_e           run;
        logic [FINE_W-1:0]   fine;
        logic [COARSE_W-1:0] coarse;
        logic                imm;
        cnt_mode_e           mode;
    } tb_ctrl_t;

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler
    import pwm_timebase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              tb_en,
    output logic              tick
);

    localparam int DIV_W = (2 ** COARSE_W - 1) + FINE_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [CTRL_W-1:0] ctrl;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    tb_ctrl_t         cfg;
    logic [DIV_W-1:0] fine_div;
    logic [DIV_W-1:0] divisor;
    logic             chg;

    assign cfg = tb_ctrl_t'(ctrl);

    always_comb begin
        if (cfg.fine == '0) begin
            fine_div = DIV_W'(1);
        end else begin
            fine_div = DIV_W'({cfg.fine, 1'b0});
        end
        divisor = fine_div << cfg.coarse;
        chg     = (ctrl != st_q.ctrl);
        tick    = tb_en && !chg && (st_q.div == (divisor - DIV_W'(1)));

        st_d      = st_q;
        st_d.ctrl = ctrl;
        if (chg) begin
            st_d.div = '0;
        end else if (tb_en) begin
            if (tick) begin
                st_d.div = '0;
            end else begin
                st_d.div = st_q.div + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             imm,
    input  logic             load_zero,
    output logic [CNT_W-1:0] prd
);

    typedef struct packed {
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] shadow;
    } prd_st_t;

    prd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_zero && !imm) begin
            st_d.active = st_q.shadow;
        end
        if (wr) begin
            st_d.shadow = wdata;
            if (imm) begin
                st_d.active = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prd = st_q.active;

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic [1:0]       run,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt,
    output logic             prd_evt,
    output logic             dir_down,
    output logic             load_zero
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ud;
        logic             dir;
        logic             zev;
        logic             pev;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    cnt_mode_e        md;
    run_mode_e        rn;
    logic [CNT_W-1:0] nxt;
    logic             ud_n;
    logic             hold;
    logic             adv;

    assign md = cnt_mode_e'(mode);
    assign rn = run_mode_e'(run);

    always_comb begin
        nxt  = st_q.cnt;
        ud_n = st_q.ud;
        hold = (rn == RUN_HALT) ||
               ((rn == RUN_FINISH) && (st_q.cnt == '0)) ||
               (md == CNT_FREEZE);
        adv  = tick && !hold;

        case (md)
            CNT_UP: begin
                if (st_q.cnt >= prd) begin
                    nxt = '0;
                end else begin
                    nxt = st_q.cnt + CNT_W'(1);
                end
            end
            CNT_DOWN: begin
                if (st_q.cnt == '0) begin
                    nxt = prd;
                end else begin
                    nxt = st_q.cnt - CNT_W'(1);
                end
            end
            CNT_UPDOWN: begin
                if (!st_q.ud) begin
                    if (st_q.cnt >= prd) begin
                        nxt  = (st_q.cnt == '0) ? '0 : st_q.cnt - CNT_W'(1);
                        ud_n = (nxt != '0);
                    end else begin
                        nxt  = st_q.cnt + CNT_W'(1);
                        ud_n = (nxt >= prd);
                    end
                end else begin
                    if (st_q.cnt == '0) begin
                        nxt  = (prd == '0) ? '0 : CNT_W'(1);
                        ud_n = (nxt != '0) && (nxt >= prd);
                    end else begin
                        nxt  = st_q.cnt - CNT_W'(1);
                        ud_n = (nxt != '0);
                    end
                end
            end
            default: nxt = st_q.cnt;
        endcase

        st_d     = st_q;
        st_d.cnt = adv ? nxt : st_q.cnt;
        if (md != CNT_UPDOWN) begin
            st_d.ud = 1'b0;
        end else if (adv) begin
            st_d.ud = ud_n;
        end

        case (md)
            CNT_UP:     st_d.dir = 1'b0;
            CNT_DOWN:   st_d.dir = 1'b1;
            CNT_UPDOWN: st_d.dir = st_d.ud;
            default:    st_d.dir = st_q.dir;
        endcase

        st_d.zev  = adv && (nxt == '0);
        st_d.pev  = adv && (nxt == prd);
        load_zero = adv && (nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.cnt;
    assign zero_evt = st_q.zev;
    assign prd_evt  = st_q.pev;
    assign dir_down = st_q.dir;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              prd_wr,
    input  logic [CNT_W-1:0]  prd_wdata,
    input  logic              tb_en,
    output logic [CNT_W-1:0]  count,
    output logic              zero_evt,
    output logic              prd_evt,
    output logic              dir_down
);

    tb_ctrl_t         cfg;
    logic             tick;
    logic             load_zero;
    logic [CNT_W-1:0] prd;

    assign cfg = tb_ctrl_t'(ctrl);

    pwm_tb_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .tb_en (tb_en),
        .tick  (tick)
    );

    pwm_tb_period #(.CNT_W(CNT_W)) u_prd (
        .clk       (clk),
        .rst       (rst),
        .wr        (prd_wr),
        .wdata     (prd_wdata),
        .imm       (cfg.imm),
        .load_zero (load_zero),
        .prd       (prd)
    );

    pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (cfg.mode),
        .run       (cfg.run),
        .prd       (prd),
        .count     (count),
        .zero_evt  (zero_evt),
        .prd_evt   (prd_evt),
        .dir_down  (dir_down),
        .load_zero (load_zero)
    );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [15:0]      ctrl,
    input logic             tb_en,
    input logic [CNT_W-1:0] count,
    input logic             zero_evt,
    input logic             dir_down
);

    // Field positions: mode [1:0], run [10:9]
    p_zero_evt_count_r6: assert property (@(posedge clk) disable iff (rst)
        zero_evt |-> (count == '0));

    p_freeze_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(ctrl[1:0]) == 2'd3)) |-> $stable(count));

    p_halt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(ctrl[10:9]) == 2'd0)) |-> $stable(count));

    p_en_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tb_en)) |-> $stable(count));

    p_down_dir_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(ctrl[1:0]) == 2'd1)) |-> dir_down);

    p_up_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(ctrl[1:0]) == 2'd0)) |-> !dir_down);

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .tb_en    (tb_en),
    .count    (count),
    .zero_evt (zero_evt),
    .dir_down (dir_down)
);

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctrl = '0;
    logic        prd_wr = 1'b0;
    logic [15:0] prd_wdata = '0;
    logic        tb_en = 1'b1;
    logic [15:0] count;
    logic        zero_evt;
    logic        prd_evt;
    logic        dir_down;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_timebase u_pwm_timebase (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .prd_wr    (prd_wr),
        .prd_wdata (prd_wdata),
        .tb_en     (tb_en),
        .count     (count),
        .zero_evt  (zero_evt),
        .prd_evt   (prd_evt),
        .dir_down  (dir_down)
    );

    function automatic logic [15:0] mk(input int mode, input int imm,
                                       input int coarse, input int fine, input int run);
        mk = {5'b0, run[1:0], fine[2:0], coarse[2:0], imm[0], mode[1:0]};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ctrl = '0; prd_wr = 1'b0; tb_en = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    task automatic set_ctrl(input logic [15:0] v);
        ctrl = v;
        step(1);
    endtask

    task automatic wr_prd(input int v);
        prd_wr = 1'b1; prd_wdata = v[15:0];
        step(1);
        prd_wr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "count", int'(count), 0);
        chk("R1", "zero_evt", int'(zero_evt), 0);
        chk("R1", "prd_evt", int'(prd_evt), 0);
        chk("R1", "dir_down", int'(dir_down), 0);
        set_ctrl(mk(0, 1, 0, 0, 3));
        step(1);
        chk("R1", "count period0", int'(count), 0);
        chk("R1", "zero_evt period0", int'(zero_evt), 1);
        chk("R1", "prd_evt period0", int'(prd_evt), 1);
    endtask

    task automatic t_up();
        do_reset();
        set_ctrl(mk(0, 1, 0, 0, 0));
        wr_prd(4);
        set_ctrl(mk(0, 1, 0, 0, 3));
        for (int i = 0; i < 7; i++) begin
            int e;
            e = (i + 1) % 5;
            step(1);
            chk("R2", "up count", int'(count), e);
            chk("R6", "up prd_evt", int'(prd_evt), (e == 4) ? 1 : 0);
            chk("R6", "up zero_evt", int'(zero_evt), (e == 0) ? 1 : 0);
            chk("R2", "up dir", int'(dir_down), 0);
        end
    endtask

    task automatic t_down();
        do_reset();
        set_ctrl(mk(1, 1, 0, 0, 0));
        wr_prd(4);
        set_ctrl(mk(1, 1, 0, 0, 3));
        for (int i = 0; i < 7; i++) begin
            int e;
            e = 4 - (i % 5);
            step(1);
            chk("R3", "down count", int'(count), e);
            chk("R3", "down dir", int'(dir_down), 1);
            chk("R6", "down zero_evt", int'(zero_evt), (e == 0) ? 1 : 0);
        end
    endtask

    task automatic t_updown();
        do_reset();
        set_ctrl(mk(2, 1, 0, 0, 0));
        wr_prd(3);
        set_ctrl(mk(2, 1, 0, 0, 3));
        for (int i = 0; i < 8; i++) begin
            int p;
            int e;
            p = (i + 1) % 6;
            e = (p <= 3) ? p : 6 - p;
            step(1);
            chk("R4", "updown count", int'(count), e);
            chk("R4", "updown dir", int'(dir_down), (p >= 3) ? 1 : 0);
            chk("R6", "updown prd_evt", int'(prd_evt), (e == 3) ? 1 : 0);
        end
    endtask

    task automatic t_freeze();
        do_reset();
        set_ctrl(mk(0, 1, 0, 0, 0));
        wr_prd(4);
        set_ctrl(mk(0, 1, 0, 0, 3));
        step(2);
        set_ctrl(mk(3, 1, 0, 0, 3));
        for (int i = 0; i < 5; i++) begin
            step(1);
            chk("R5", "freeze count", int'(count), 2);
            chk("R5", "freeze events", int'(zero_evt) + int'(prd_evt), 0);
        end
    endtask

    task automatic t_halt();
        do_reset();
        set_ctrl(mk(0, 1, 0, 0, 0));
        wr_prd(10);
        set_ctrl(mk(0, 1, 0, 0, 3));
        step(5);
        chk("R7", "before halt", int'(count), 5);
        set_ctrl(mk(0, 1, 0, 0, 0));
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk("R7", "halt count", int'(count), 5);
        end
    endtask

    task automatic t_finish();
        do_reset();
        set_ctrl(mk(0, 1, 0, 0, 0));
        wr_prd(5);
        set_ctrl(mk(0, 1, 0, 0, 3));
        step(2);
        set_ctrl(mk(0, 1, 0, 0, 1));
        chk("R8", "finish start", int'(count), 2);
        for (int i = 0; i < 4; i++) begin
            int e;
            e = (i < 3) ? i + 3 : 0;
            step(1);
            chk("R8", "finish count", int'(count), e);
        end
        chk("R8", "finish zero_evt", int'(zero_evt), 1);
        for (int i = 0; i < 3; i++) begin
            step(1);
            chk("R8", "rest count", int'(count), 0);
            chk("R8", "rest zero_evt", int'(zero_evt), 0);
        end
    endtask

    task automatic t_prescale();
        do_reset();
        set_ctrl(mk(0, 1, 0, 0, 0));
        wr_prd(100);
        set_ctrl(mk(0, 1, 1, 3, 3));
        step(11);
        chk("R9", "div12 early", int'(count), 0);
        step(1);
        chk("R9", "div12 tick", int'(count), 1);
        step(11);
        chk("R9", "div12 early2", int'(count), 1);
        step(1);
        chk("R9", "div12 tick2", int'(count), 2);
        set_ctrl(mk(0, 1, 2, 0, 3));
        step(3);
        chk("R9", "div4 early", int'(count), 2);
        step(1);
        chk("R9", "div4 tick", int'(count), 3);
        step(2);
        set_ctrl(mk(0, 1, 2, 0, 3) | 16'h8000);
        step(3);
        chk("R10", "restart early", int'(count), 3);
        step(1);
        chk("R10", "restart tick", int'(count), 4);
        set_ctrl(mk(0, 1, 7, 7, 3));
        step(1791);
        chk("R9", "div1792 early", int'(count), 4);
        step(1);
        chk("R9", "div1792 tick", int'(count), 5);
    endtask

    task automatic t_enable();
        do_reset();
        set_ctrl(mk(0, 1, 0, 0, 0));
        wr_prd(10);
        set_ctrl(mk(0, 1, 0, 0, 3));
        step(3);
        tb_en = 1'b0;
        step(5);
        chk("R11", "disabled count", int'(count), 3);
        tb_en = 1'b1;
        step(1);
        chk("R11", "enabled count", int'(count), 4);
    endtask

    task automatic t_immediate();
        do_reset();
        set_ctrl(mk(0, 1, 0, 0, 0));
        wr_prd(6);
        set_ctrl(mk(0, 1, 0, 0, 3));
        step(1);
        tb_en = 1'b0;
        wr_prd(2);
        tb_en = 1'b1;
        step(1);
        chk("R12", "imm count", int'(count), 2);
        chk("R12", "imm prd_evt", int'(prd_evt), 1);
        step(1);
        chk("R12", "imm wrap", int'(count), 0);
    endtask

    task automatic t_shadow();
        do_reset();
        set_ctrl(mk(0, 1, 0, 0, 0));
        wr_prd(4);
        set_ctrl(mk(0, 0, 0, 0, 3));
        step(1);
        tb_en = 1'b0;
        wr_prd(2);
        tb_en = 1'b1;
        step(1);
        chk("R13", "old prd count", int'(count), 2);
        chk("R13", "old prd no evt", int'(prd_evt), 0);
        step(2);
        chk("R13", "old prd reached", int'(count), 4);
        chk("R13", "old prd evt", int'(prd_evt), 1);
        step(1);
        chk("R13", "wrap", int'(count), 0);
        step(2);
        chk("R13", "new prd count", int'(count), 2);
        chk("R13", "new prd evt", int'(prd_evt), 1);
        step(1);
        chk("R13", "new wrap", int'(count), 0);
    endtask

    initial begin
        t_reset();
        t_up();
        t_down();
        t_updown();
        t_freeze();
        t_halt();
        t_finish();
        t_prescale();
        t_enable();
        t_immediate();
        t_shadow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule